// File: doc/BRIEF.md
# Multiplexed video bus encoder

This block serializes one pixel onto a narrow video bus running at four times the pixel rate. Each pixel becomes a group of four bus beats. On the first beat the strobe is low and the bus carries four active-low sync and control flags. On the next three beats the strobe is high and the bus carries the red, green and blue components.

During blanking the source deasserts its pixel-valid input. The encoder then stays on the control beat: the strobe is held low and a freshly sampled control word is driven on every clock, so sync edges can be placed with single-beat resolution.

All inputs are sampled once, on the edge that emits a control beat. The colour samples are held for the rest of the group. A group that has started always runs to its end. Mode changes therefore take effect only at group boundaries.

Top module: `vbus_enc`

## Requirements
- R1: While rst_ni is low, strobe_no is 0 and bus_o is 7'b000_1111 (all four flags inactive, colour bits 0).
- R2: A control beat has strobe_no = 0. bus_o[0..3] hold csync_ni, hsync_ni, clamp_ni and vsync_ni, as sampled on the edge that emits the beat.
- R3: On every control beat, bus_o[6:4] is 0.
- R4: When active_i is 1 at a control beat, the next three beats have strobe_no = 1 and carry red, green and blue in that order. Component bit n appears on bus bit n.
- R5: The colour values sent in a group are the ones sampled at its control beat. Input changes during the three colour beats have no effect on the bus.
- R6: When active_i is 0 at a control beat, the next beat is again a control beat. Consecutive blanking beats each carry the flags sampled on their own edge.
- R7: A started group always completes. Dropping active_i during colour beats does not cut the group short. A switch from blanking to active begins at the next control beat.
- R8: The strobe is never high for more than three consecutive beats. Under continuous active video it is low exactly once every four beats.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock, four times the pixel rate |
| rst_ni | input | 1 | Asynchronous active-low reset |
| active_i | input | 1 | 1 = active pixel, 0 = blanking |
| red_i | input | 7 | Red component |
| green_i | input | 7 | Green component |
| blue_i | input | 7 | Blue component |
| csync_ni | input | 1 | Composite sync, active low |
| hsync_ni | input | 1 | Horizontal sync, active low |
| clamp_ni | input | 1 | Clamp / burst gate, active low |
| vsync_ni | input | 1 | Vertical sync, active low |
| bus_o | output | 7 | Multiplexed video data |
| strobe_no | output | 1 | Low on control beats |

## Verification
Every bus beat is registered once. The beat driven from the inputs applied before a rising edge appears just after that edge. Colour beats follow their control beat on the next three edges, carrying values captured at the control edge.

The driver applies inputs on falling edges and pushes one expected beat per clock into a queue. The monitor pops one entry a short delay after each rising edge, so each comparison lands on the cycle in which the result is due. Scrambled inputs and a dropped pixel-valid during colour beats show that captured values and group length are unaffected.

// File: rtl/vbus_enc_pkg.sv
package vbus_enc_pkg;
  localparam int unsigned PIX_W  = 7;
  localparam int unsigned FLAG_W = 4;

  typedef enum logic [1:0] {
    BEAT_CTRL = 2'd0,
    BEAT_RED  = 2'd1,
    BEAT_GRN  = 2'd2,
    BEAT_BLU  = 2'd3
  } beat_e;

  // flag order matches bus lanes 0..3
  typedef struct packed {
    logic vsync_n;
    logic clamp_n;
    logic hsync_n;
    logic csync_n;
  } flags_t;

  localparam flags_t FLAGS_IDLE = '{vsync_n: 1'b1, clamp_n: 1'b1, hsync_n: 1'b1, csync_n: 1'b1};
endpackage

// File: rtl/vbus_beat_seq.sv
module vbus_beat_seq
  import vbus_enc_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  active_i,
  output beat_e beat_o,
  output logic  load_o
);
  beat_e beat_q, beat_d;

  always_comb begin
    unique case (beat_q)
      BEAT_CTRL: beat_d = active_i ? BEAT_RED : BEAT_CTRL;
      BEAT_RED:  beat_d = BEAT_GRN;
      BEAT_GRN:  beat_d = BEAT_BLU;
      default:   beat_d = BEAT_CTRL;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) beat_q <= BEAT_CTRL;
    else         beat_q <= beat_d;
  end

  assign beat_o = beat_q;
  assign load_o = (beat_q == BEAT_CTRL);

  // R7: colour beats never fall back to control before blue
  p_no_abort_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (beat_q == BEAT_RED) |=> (beat_q == BEAT_GRN));
  // R6: blanking at a control beat stays on control
  p_blank_stay_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_o && !active_i) |=> load_o);
endmodule

// File: rtl/vbus_pix_hold.sv
module vbus_pix_hold #(
  parameter int unsigned COMP_W = vbus_enc_pkg::PIX_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [COMP_W-1:0] red_i,
  input  logic [COMP_W-1:0] green_i,
  input  logic [COMP_W-1:0] blue_i,
  output logic [COMP_W-1:0] red_o,
  output logic [COMP_W-1:0] green_o,
  output logic [COMP_W-1:0] blue_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      red_o   <= '0;
      green_o <= '0;
      blue_o  <= '0;
    end else if (load_i) begin
      red_o   <= red_i;
      green_o <= green_i;
      blue_o  <= blue_i;
    end
  end

  // R5: held pixel frozen outside the control beat
  p_hold_stable_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> ($stable(red_o) && $stable(green_o) && $stable(blue_o)));
endmodule

// File: rtl/vbus_out_mux.sv
module vbus_out_mux
  import vbus_enc_pkg::*;
#(
  parameter int unsigned COMP_W = PIX_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  beat_e             beat_i,
  input  flags_t            flags_i,
  input  logic [COMP_W-1:0] red_i,
  input  logic [COMP_W-1:0] green_i,
  input  logic [COMP_W-1:0] blue_i,
  output logic [COMP_W-1:0] bus_o,
  output logic              strobe_no
);
  localparam int unsigned SPARE_W = COMP_W - FLAG_W;

  logic [COMP_W-1:0] ctrl_word;
  logic [COMP_W-1:0] bus_d;
  logic [COMP_W-1:0] bus_rst;

  for (genvar i = 0; i < COMP_W; i++) begin : g_lane
    if (i < FLAG_W) begin : g_flag
      assign ctrl_word[i] = flags_i[i];
      assign bus_rst[i]   = FLAGS_IDLE[i];
    end else begin : g_spare
      assign ctrl_word[i] = 1'b0;
      assign bus_rst[i]   = 1'b0;
    end
  end

  always_comb begin
    unique case (beat_i)
      BEAT_RED:  bus_d = red_i;
      BEAT_GRN:  bus_d = green_i;
      BEAT_BLU:  bus_d = blue_i;
      default:   bus_d = ctrl_word;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bus_o     <= bus_rst;
      strobe_no <= 1'b0;
    end else begin
      bus_o     <= bus_d;
      strobe_no <= (beat_i != BEAT_CTRL);
    end
  end

  // R3: spare lanes zero whenever the strobe is low
  p_spare_zero_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !strobe_no |-> (bus_o[COMP_W-1:FLAG_W] == SPARE_W'(0)));
  // R2: control lanes carry the flags seen at the emitting edge
  p_ctrl_flags_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!strobe_no && $past(rst_ni)) |-> (bus_o[FLAG_W-1:0] == $past(flags_i)));
  // R4: red beat carries held red
  p_red_lane_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (beat_i == BEAT_RED) |=> (strobe_no && bus_o == $past(red_i)));
endmodule

// File: rtl/vbus_enc.sv
module vbus_enc
  import vbus_enc_pkg::*;
#(
  parameter int unsigned COMP_W = PIX_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              active_i,
  input  logic [COMP_W-1:0] red_i,
  input  logic [COMP_W-1:0] green_i,
  input  logic [COMP_W-1:0] blue_i,
  input  logic              csync_ni,
  input  logic              hsync_ni,
  input  logic              clamp_ni,
  input  logic              vsync_ni,
  output logic [COMP_W-1:0] bus_o,
  output logic              strobe_no
);
  beat_e             beat;
  logic              load;
  flags_t            flags;
  logic [COMP_W-1:0] red_h, green_h, blue_h;

  assign flags = '{vsync_n: vsync_ni, clamp_n: clamp_ni, hsync_n: hsync_ni, csync_n: csync_ni};

  vbus_beat_seq u_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .active_i (active_i),
    .beat_o   (beat),
    .load_o   (load)
  );

  vbus_pix_hold #(.COMP_W(COMP_W)) u_hold (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (load),
    .red_i   (red_i),
    .green_i (green_i),
    .blue_i  (blue_i),
    .red_o   (red_h),
    .green_o (green_h),
    .blue_o  (blue_h)
  );

  vbus_out_mux #(.COMP_W(COMP_W)) u_mux (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .beat_i    (beat),
    .flags_i   (flags),
    .red_i     (red_h),
    .green_i   (green_h),
    .blue_i    (blue_h),
    .bus_o     (bus_o),
    .strobe_no (strobe_no)
  );

  // high-strobe run length, for R8/R7 checks
  logic [1:0] hi_run_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        hi_run_q <= '0;
    else if (!strobe_no) hi_run_q <= '0;
    else if (hi_run_q != 2'd3) hi_run_q <= hi_run_q + 2'd1;
  end

  p_run_max_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_no |-> (hi_run_q < 2'd3));
  p_group_full_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strobe_no && hi_run_q < 2'd2) |=> strobe_no);
  p_blank_low_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load && !active_i) |=> !strobe_no);
endmodule

// File: tb/vbus_enc_bench.sv
module vbus_enc_bench;
  typedef struct {
    logic       strobe_n;
    logic [6:0] bus;
    string      req;
  } exp_t;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       active_i = 1'b0;
  logic [6:0] red_i = '0, green_i = '0, blue_i = '0;
  logic       csync_ni = 1'b1, hsync_ni = 1'b1, clamp_ni = 1'b1, vsync_ni = 1'b1;
  logic [6:0] bus_o;
  logic       strobe_no;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  exp_t expq[$];

  always #2 clk_i = ~clk_i;

  vbus_enc u_vbus_enc (
    .clk_i(clk_i), .rst_ni(rst_ni), .active_i(active_i),
    .red_i(red_i), .green_i(green_i), .blue_i(blue_i),
    .csync_ni(csync_ni), .hsync_ni(hsync_ni), .clamp_ni(clamp_ni), .vsync_ni(vsync_ni),
    .bus_o(bus_o), .strobe_no(strobe_no)
  );

  task automatic check(input string req, input logic s_exp, input logic [6:0] b_exp);
    checks++;
    if (strobe_no !== s_exp || bus_o !== b_exp) begin
      errors++;
      $display("FAIL %s strobe=%b bus=%h expected strobe=%b bus=%h", req, strobe_no, bus_o, s_exp, b_exp);
    end
  endtask

  // flags = {vsync,clamp,hsync,csync}
  function automatic logic [6:0] ctrl(input logic [3:0] f);
    return {3'b000, f};
  endfunction

  task automatic set_in(input logic act, input logic [6:0] r, input logic [6:0] g,
                        input logic [6:0] b, input logic [3:0] f);
    active_i = act; red_i = r; green_i = g; blue_i = b;
    {vsync_ni, clamp_ni, hsync_ni, csync_ni} = f;
  endtask

  // one blanking beat (R6, R2, R3)
  task automatic blank(input logic [3:0] f);
    set_in(1'b0, 7'h5a, 7'h33, 7'h0f, f);
    expq.push_back('{1'b0, ctrl(f), "R6"});
    @(negedge clk_i);
  endtask

  // one active pixel group; scramble changes all inputs during colour beats (R5, R7)
  task automatic pixel(input logic [6:0] r, input logic [6:0] g, input logic [6:0] b,
                       input logic [3:0] f, input bit scramble);
    set_in(1'b1, r, g, b, f);
    expq.push_back('{1'b0, ctrl(f), "R2"});
    @(negedge clk_i);
    for (int i = 0; i < 3; i++) begin
      if (scramble) set_in(1'b0, ~r ^ 7'(i), ~g, ~b, ~f);
      expq.push_back('{1'b1, (i == 0) ? r : (i == 1) ? g : b, scramble ? "R5" : "R4"});
      @(negedge clk_i);
    end
  endtask

  // monitor: result due just after the edge following each drive
  initial begin
    forever begin
      @(posedge clk_i);
      #1;
      if (rst_ni && expq.size() > 0) begin
        exp_t e;
        e = expq.pop_front();
        check(e.req, e.strobe_n, e.bus);
      end
    end
  end

  initial begin
    #200000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    set_in(1'b1, 7'h7f, 7'h7f, 7'h7f, 4'b0000);
    repeat (3) @(negedge clk_i);
    check("R1", 1'b0, 7'b000_1111);        // R1 reset values, inputs ignored
    rst_ni = 1'b1;
    // R6 blanking with changing flags each beat
    blank(4'b1111);
    blank(4'b1110);
    blank(4'b1100);
    blank(4'b0101);
    blank(4'b1010);
    // R7 blank -> active at group start, R4 order and bit mapping
    pixel(7'h01, 7'h02, 7'h04, 4'b1111, 1'b0);
    pixel(7'h7f, 7'h00, 7'h55, 4'b1011, 1'b0);   // R8 back-to-back groups
    pixel(7'h2a, 7'h40, 7'h13, 4'b0110, 1'b0);
    // R5/R7 inputs scrambled and active dropped mid-group
    pixel(7'h11, 7'h22, 7'h44, 4'b1101, 1'b1);
    pixel(7'h6c, 7'h19, 7'h70, 4'b0011, 1'b1);
    // R3 control word spare bits with all-ones colours
    blank(4'b0000);
    pixel(7'h7f, 7'h7f, 7'h7f, 4'b0000, 1'b0);
    blank(4'b1111);
    blank(4'b0111);
    pixel(7'h08, 7'h10, 7'h20, 4'b1110, 1'b0);
    set_in(1'b0, '0, '0, '0, 4'b1111);
    repeat (2) @(posedge clk_i);
    #1;
    if (expq.size() != 0) begin
      errors++;
      $display("FAIL R8 pending beats %0d expected 0", expq.size());
    end
    @(negedge clk_i);
    set_in(1'b1, 7'h55, 7'h2a, 7'h7f, 4'b0000);
    rst_ni = 1'b0;
    #1;
    check("R1", 1'b0, 7'b000_1111);        // R1 async reset mid-run
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule